// File: doc/BRIEF.md
# Dual Status Byte I2C Read Responder

This block answers the read side of an I2C target. It oversamples the serial clock and data lines on a fast system clock, finds START and STOP conditions, and collects the first byte after each START. When that byte carries the block's 7-bit address with the direction bit set to read, the block acknowledges. It then shifts out two status bytes, always in the same order, without any register-index phase. Between the bytes it samples the controller's acknowledge.

The two status values come in as parallel words from neighbouring logic. Both are captured together into a shadow copy when the address is accepted, so the pair a controller reads always belongs to the same instant. The data line is open-drain. The block only ever asks for it to be pulled low, through `sda_oe`, and it reads the resolved line on `sda_in`. A write-direction or foreign address leaves the block silent.

Top module: `i2c_status_reader`

## Requirements
- R1: After reset, `sda_oe` is 0 (line released) and stays 0 until a matching address has been received.
- R2: After a START followed by the byte {DEV_ADDR, 1'b1} (default DEV_ADDR = 7'b1100000, sent MSB first, so the byte is 8'hC1), `sda_oe` is 1 throughout the high phase of the ninth SCL pulse (ACK).
- R3: Any other first byte, including the write form {DEV_ADDR, 1'b0} = 8'hC0, produces no ACK, and `sda_oe` stays 0 until the next START.
- R4: After the address ACK, the block returns `stat_first` and then `stat_second`, each MSB first. A data bit of 0 is shown as `sda_oe` = 1 and a 1 as `sda_oe` = 0.
- R5: Both status inputs are captured at the address-accept point (the SCL fall ending the eighth address bit). Changes to them after that point do not alter the bytes returned in that transfer.
- R6: A NACK (SDA high in the ninth clock) after the first byte releases the line, and no second byte is driven before the next START.
- R7: After the second byte, whether the controller sends ACK or NACK, the line stays released and no further data is driven.
- R8: `sda_oe` only becomes 1 while the synchronised SCL is low.
- R9: A START seen at any point, including in the middle of a byte, restarts address reception from bit 0. A repeated START then allows a fresh read.
- R10: A STOP returns the block to idle with the line released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Resolved serial data line |
| stat_first | input | 8 | Status value returned as the first byte |
| stat_second | input | 8 | Status value returned as the second byte |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with its default address, 7'b1100000. This allows a read byte (8'hC1), its write twin (8'hC0) and an unrelated address (8'h61) to be compared against one match comparator. The SCL half period is eight system clocks, which leaves enough room for the two-flop synchroniser and edge stage to settle inside every phase. Within that window, the expected drive state is checked on every clock outside the short settling window after each SCL fall. Mid-byte restarts, NACK and ACK endings, and status changes during a transfer are all reachable at that setting.

// File: rtl/i2c_status_reader.sv
`timescale 1ns/1ps
module i2c_status_reader #(
  parameter logic [6:0] DEV_ADDR = 7'b1100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [7:0] stat_first,
  input  logic [7:0] stat_second,
  output logic       sda_oe
);

  localparam logic [7:0] RD_BYTE = {DEV_ADDR, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_SEND, S_MACK, S_WAIT} state_t;

  logic [1:0]  scl_sy, sda_sy;
  logic        scl_q, sda_q;
  state_t      state;
  logic [3:0]  cnt;
  logic [7:0]  sh;
  logic [15:0] shadow;
  logic        sel, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  wire [7:0] cur     = sel ? shadow[7:0] : shadow[15:8];
  wire [2:0] nxt_idx = 3'd6 - cnt[2:0];
  wire       hit     = (sh == RD_BYTE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      shadow <= '0;
      sel    <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (hit) begin
              state  <= S_AACK;
              sda_oe <= 1'b1;
              shadow <= {stat_first, stat_second};
            end else begin
              state  <= S_WAIT;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          state  <= S_SEND;
          cnt    <= '0;
          sel    <= 1'b0;
          sda_oe <= ~shadow[15];
        end
        S_SEND: if (scl_fall) begin
          if (cnt == 4'd7) begin
            state  <= S_MACK;
            sda_oe <= 1'b0;
          end else begin
            cnt    <= cnt + 4'd1;
            sda_oe <= ~cur[nxt_idx];
          end
        end
        S_MACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack && !sel) begin
              state  <= S_SEND;
              sel    <= 1'b1;
              cnt    <= '0;
              sda_oe <= ~shadow[7];
            end else begin
              state  <= S_WAIT;
              sda_oe <= 1'b0;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end

  assert_drive_only_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  assert_released_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK || state == S_WAIT) |-> !sda_oe);

  assert_stop_after_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK && sel && scl_fall && !start_c && !stop_c) |=> (state == S_WAIT));

  assert_miss_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && scl_fall && cnt == 4'd8 && !hit) |=> (state == S_WAIT && !sda_oe));

  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == S_ADDR && cnt == 4'd0 && !sda_oe));

endmodule

// File: tb/i2c_status_reader_test.sv
`timescale 1ns/1ps
module i2c_status_reader_test;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [7:0] s1 = 8'h00, s2 = 8'h00;
  logic sda_oe;
  wire  line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_status_reader uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(line),
    .stat_first(s1), .stat_second(s2), .sda_oe(sda_oe)
  );

  int total = 0, bad = 0;
  logic exp_oe = 1'b0;
  int guard = 0;
  logic mon_on = 1'b0;
  string tag = "R1";

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (guard > 0) guard--;
      else begin
        total++;
        if (sda_oe !== exp_oe) begin
          bad++;
          $display("FAIL %s per-clock sda_oe actual=%0b expected=%0b t=%0t", tag, sda_oe, exp_oe, $time);
        end
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r, input logic nxt);
    m_sda = b; wt(H);
    m_scl = 1'b1; wt(H/2);
    r = line; wt(H/2);
    m_scl = 1'b0; exp_oe = nxt; guard = 4;
  endtask

  task automatic do_start();
    m_sda = 1'b1; wt(H);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(H);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wt(H);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic addr_byte(input logic [7:0] b, input logic hit, input logic first_msb, input string req);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r, (i == 0) ? hit : 1'b0);
    clk_bit(1'b1, r, hit ? ~first_msb : 1'b0);
    check(req, {7'd0, r}, {7'd0, ~hit});
  endtask

  task automatic read_byte(input logic [7:0] e, input logic ack, input logic nxt_after, input string req);
    logic r;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r, (i > 0) ? ~e[i-1] : 1'b0);
      got[i] = r;
    end
    check(req, got, e);
    clk_bit(~ack, r, nxt_after);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic r;
    wt(5);
    check("R1", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    wt(3);
    mon_on = 1'b1;
    wt(20);
    check("R1", {7'd0, sda_oe}, 8'h00);

    // R2 R4: basic read, ACK then NACK
    s1 = 8'hA5; s2 = 8'h3C;
    tag = "R2"; do_start();
    addr_byte(8'hC1, 1'b1, s1[7], "R2");
    tag = "R4";
    read_byte(8'hA5, 1'b1, ~s2[7], "R4");
    read_byte(8'h3C, 1'b0, 1'b0, "R4");
    tag = "R10"; do_stop(); wt(10);
    check("R10", {7'd0, sda_oe}, 8'h00);

    // R5: inputs change after address accept
    s1 = 8'h0F; s2 = 8'hF0;
    tag = "R5"; do_start();
    addr_byte(8'hC1, 1'b1, 1'b0, "R2");
    s1 = 8'hFF; s2 = 8'h00;
    read_byte(8'h0F, 1'b1, ~1'b1, "R5");
    s1 = 8'h55;
    read_byte(8'hF0, 1'b0, 1'b0, "R5");
    do_stop();

    // R6: NACK after first byte
    s1 = 8'h81; s2 = 8'h00;
    tag = "R6"; do_start();
    addr_byte(8'hC1, 1'b1, 1'b1, "R2");
    read_byte(8'h81, 1'b0, 1'b0, "R6");
    read_byte(8'hFF, 1'b0, 1'b0, "R6");
    do_stop();

    // R7: ACK after second byte, then extra clocks
    s1 = 8'h12; s2 = 8'h34;
    tag = "R7"; do_start();
    addr_byte(8'hC1, 1'b1, 1'b0, "R2");
    read_byte(8'h12, 1'b1, ~1'b0, "R4");
    read_byte(8'h34, 1'b1, 1'b0, "R7");
    read_byte(8'hFF, 1'b1, 1'b0, "R7");
    do_stop();

    // R3: write direction and foreign address
    tag = "R3"; do_start();
    addr_byte(8'hC0, 1'b0, 1'b0, "R3");
    read_byte(8'hFF, 1'b1, 1'b0, "R3");
    do_stop();
    do_start();
    addr_byte(8'h61, 1'b0, 1'b0, "R3");
    read_byte(8'hFF, 1'b1, 1'b0, "R3");
    do_stop();

    // R9: START in the middle of the address byte
    s1 = 8'h6E; s2 = 8'h91;
    tag = "R9"; do_start();
    clk_bit(1'b1, r, 1'b0);
    clk_bit(1'b1, r, 1'b0);
    clk_bit(1'b0, r, 1'b0);
    do_start();
    addr_byte(8'hC1, 1'b1, 1'b0, "R9");
    read_byte(8'h6E, 1'b1, ~1'b1, "R9");
    read_byte(8'h91, 1'b0, 1'b0, "R9");

    // R9: repeated START right after a read, no STOP between
    s1 = 8'hC3; s2 = 8'h7E;
    do_start();
    addr_byte(8'hC1, 1'b1, 1'b1, "R9");
    read_byte(8'hC3, 1'b1, ~1'b0, "R9");
    read_byte(8'h7E, 1'b0, 1'b0, "R9");
    tag = "R10"; do_stop(); wt(20);
    check("R10", {7'd0, sda_oe}, 8'h00);

    // R1: after a fresh reset the line is released
    mon_on = 1'b0;
    rst_n = 1'b0; wt(4);
    check("R1", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1; wt(10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule